// File: doc/BRIEF.md
# I2C Slave Address Matcher with Wake

This block is the receive-side front end of an I2C target. It resynchronises the SCL and SDA lines into the system clock, finds START and STOP conditions, and shifts in the first byte after every START. The upper seven bits of that byte are compared in hardware with a programmed station address. On a hit the block pulls SDA low for the acknowledge clock and emits a single-cycle wake pulse, which a power controller can use to bring the rest of the chip out of a sleep state without any host help.

After a matched write the block keeps receiving. Each further byte is acknowledged in hardware and handed to the host as a whole byte with a one-cycle strobe, so the host deals in bytes and never in bits. A two-bit mode input selects disabled, target-only, controller-only or both. The target behaviour, and with it the START interrupt, is active only in the target-only and both modes. In controller-only mode a START from another device on the bus raises nothing.

Top module: `i2c_addr_wake`

## Requirements
- R1: After reset, sda_pull, start_irq, wake, rx_valid, rx_is_addr and rx_byte are all zero.
- R2: With mode 2'b01 (target only) or 2'b11 (both), every START (SDA falling while SCL is high) gives exactly one start_irq pulse, one clock cycle wide.
- R3: With mode 2'b00 (off) or 2'b10 (controller only), a START and a matching address give no start_irq, no wake and no acknowledge.
- R4: The address byte is taken MSB first on SCL rising edges, and its eighth bit is the read/write flag (1 = read). wake pulses exactly once when bits 7..1 equal own_addr, and never otherwise.
- R5: On an address match sda_pull is high while SCL is high in the ninth clock, and it drops after the ninth SCL falling edge. On a mismatch sda_pull stays low.
- R6: On an address match, rx_valid pulses once with rx_byte equal to the full address byte and rx_is_addr = 1.
- R7: After a matched write address, each following byte gives one rx_valid pulse with that byte and rx_is_addr = 0, and is acknowledged on the ninth clock.
- R8: After a mismatch or a matched read address, bytes clocked on the bus are neither acknowledged nor reported until the next START.
- R9: A STOP (SDA rising while SCL is high) returns the block to idle from any state. A partly shifted address is dropped without a wake, and the next transfer is handled normally.
- R10: A repeated START (no STOP before it) begins a new address phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 2 | 00 off, 01 target only, 10 controller only, 11 both |
| own_addr | input | 7 | Programmed 7-bit station address |
| scl_in | input | 1 | SCL line level (asynchronous) |
| sda_in | input | 1 | SDA line level (asynchronous) |
| sda_pull | output | 1 | 1 = drive SDA low (open-drain acknowledge) |
| start_irq | output | 1 | One-cycle pulse on a START seen while target mode is on |
| wake | output | 1 | One-cycle pulse on a hardware address match |
| rx_valid | output | 1 | One-cycle strobe: rx_byte holds a completed byte |
| rx_byte | output | 8 | Last completed byte |
| rx_is_addr | output | 1 | The byte in rx_byte is the matched address byte |

## Verification
A wrong bit counter or a corrupted shift register shows at the ports within the same byte. The acknowledge lands on the wrong clock, or rx_byte differs from the byte on the bus, as soon as the ninth SCL high phase. A state that fails to return to idle on STOP, or on a mismatch, shows as a stray acknowledge or a stray rx_valid during the next bytes clocked on the bus, before any new START. The bench sweeps all 128 addresses against a fixed station address and all four modes, and it also runs data writes, reads, aborted addresses and repeated STARTs, so any of these faults shows within one transfer.

// File: rtl/i2c_aw_pkg.sv
package i2c_aw_pkg;
  typedef enum logic [1:0] {
    MODE_OFF    = 2'b00,
    MODE_TARGET = 2'b01,
    MODE_CTRL   = 2'b10,
    MODE_BOTH   = 2'b11
  } aw_mode_t;

  typedef enum logic [2:0] {
    S_IDLE,
    S_SHIFT,
    S_ACK_SETUP,
    S_ACK_HOLD,
    S_SKIP
  } aw_state_t;
endpackage

// File: rtl/i2c_aw_sync.sv
module i2c_aw_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_in,
  input  logic sda_in,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  localparam int LINES = 2;

  logic [LINES-1:0] line_in;
  logic [LINES-1:0] lvl;
  logic [LINES-1:0] prv;

  assign line_in = {sda_in, scl_in};

  for (genvar l = 0; l < LINES; l++) begin : g_line
    logic [STAGES-1:0] ff;
    logic              prev;
    always_ff @(posedge clk) begin
      if (rst) begin
        ff   <= '1;
        prev <= 1'b1;
      end else begin
        ff[0] <= line_in[l];
        for (int i = 1; i < STAGES; i++) ff[i] <= ff[i-1];
        prev <= ff[STAGES-1];
      end
    end
    assign lvl[l] = ff[STAGES-1];
    assign prv[l] = prev;
  end

  assign sda_lvl   = lvl[1];
  assign scl_rise  = lvl[0] & ~prv[0];
  assign scl_fall  = ~lvl[0] & prv[0];
  assign start_det = lvl[0] & prv[0] & prv[1] & ~lvl[1];
  assign stop_det  = lvl[0] & prv[0] & ~prv[1] & lvl[1];
endmodule

// File: rtl/i2c_aw_fsm.sv
module i2c_aw_fsm
  import i2c_aw_pkg::*;
#(
  parameter int AW = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          slave_en,
  input  logic [AW-1:0] own_addr,
  input  logic          sda_lvl,
  input  logic          scl_rise,
  input  logic          scl_fall,
  input  logic          start_det,
  input  logic          stop_det,
  output logic          sda_pull,
  output logic          start_irq,
  output logic          wake,
  output logic          rx_valid,
  output logic [AW:0]   rx_byte,
  output logic          rx_is_addr
);
  localparam int BW = AW + 1;
  localparam int CW = $clog2(BW);
  localparam logic [CW-1:0] LAST = CW'(BW - 1);

  aw_state_t     state;
  logic [CW-1:0] cnt;
  logic [BW-1:0] shreg;
  logic [BW-1:0] byte_nxt;
  logic          in_addr;
  logic          rw_q;

  always_comb byte_nxt = {shreg[BW-2:0], sda_lvl};

  always_ff @(posedge clk) begin
    start_irq <= 1'b0;
    wake      <= 1'b0;
    rx_valid  <= 1'b0;
    if (rst) begin
      state      <= S_IDLE;
      cnt        <= '0;
      shreg      <= '0;
      in_addr    <= 1'b0;
      rw_q       <= 1'b0;
      sda_pull   <= 1'b0;
      rx_byte    <= '0;
      rx_is_addr <= 1'b0;
    end else if (!slave_en) begin
      state    <= S_IDLE;
      sda_pull <= 1'b0;
    end else if (stop_det) begin
      state    <= S_IDLE;
      sda_pull <= 1'b0;
    end else if (start_det) begin
      state     <= S_SHIFT;
      cnt       <= '0;
      in_addr   <= 1'b1;
      sda_pull  <= 1'b0;
      start_irq <= 1'b1;
    end else begin
      unique case (state)
        S_SHIFT: if (scl_rise) begin
          shreg <= byte_nxt;
          if (cnt == LAST) begin
            cnt <= '0;
            if (in_addr) begin
              if (byte_nxt[BW-1:1] == own_addr) begin
                wake       <= 1'b1;
                rx_valid   <= 1'b1;
                rx_byte    <= byte_nxt;
                rx_is_addr <= 1'b1;
                rw_q       <= byte_nxt[0];
                state      <= S_ACK_SETUP;
              end else begin
                state <= S_IDLE;
              end
            end else begin
              rx_valid   <= 1'b1;
              rx_byte    <= byte_nxt;
              rx_is_addr <= 1'b0;
              state      <= S_ACK_SETUP;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_ACK_SETUP: if (scl_fall) begin
          sda_pull <= 1'b1;
          state    <= S_ACK_HOLD;
        end
        S_ACK_HOLD: if (scl_fall) begin
          sda_pull <= 1'b0;
          in_addr  <= 1'b0;
          state    <= (in_addr && rw_q) ? S_SKIP : S_SHIFT;
        end
        default: ;
      endcase
    end
  end

  // R2: a START interrupt is always a lone one-cycle pulse
  p_start_irq_single_r2: assert property (@(posedge clk) disable iff (rst)
    start_irq |=> !start_irq);

  // R3: no interrupt unless target mode was on when the START was seen
  p_irq_gated_r3: assert property (@(posedge clk) disable iff (rst)
    start_irq |-> $past(slave_en));

  // R4/R6: a wake comes with the address byte strobe carrying the station address
  p_wake_is_addr_r4: assert property (@(posedge clk) disable iff (rst)
    wake |-> (rx_valid && rx_is_addr && rx_byte[BW-1:1] == $past(own_addr)));

  // R5: the acknowledge is only ever applied after an SCL falling edge
  p_pull_after_fall_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_pull) |-> $past(scl_fall));

  // R7: data byte strobes never carry a wake
  p_data_no_wake_r7: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && !rx_is_addr) |-> !wake);

  // R9: STOP forces idle and releases SDA
  p_stop_idle_r9: assert property (@(posedge clk) disable iff (rst)
    (stop_det && slave_en) |=> (!sda_pull && state == S_IDLE));
endmodule

// File: rtl/i2c_addr_wake.sv
module i2c_addr_wake
  import i2c_aw_pkg::*;
#(
  parameter int AW          = 7,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [1:0]    mode,
  input  logic [AW-1:0] own_addr,
  input  logic          scl_in,
  input  logic          sda_in,
  output logic          sda_pull,
  output logic          start_irq,
  output logic          wake,
  output logic          rx_valid,
  output logic [AW:0]   rx_byte,
  output logic          rx_is_addr
);
  logic slave_en;
  logic sda_lvl, scl_rise, scl_fall, start_det, stop_det;

  assign slave_en = (aw_mode_t'(mode) == MODE_TARGET) || (aw_mode_t'(mode) == MODE_BOTH);

  i2c_aw_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst       (rst),
    .scl_in    (scl_in),
    .sda_in    (sda_in),
    .sda_lvl   (sda_lvl),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  i2c_aw_fsm #(.AW(AW)) u_fsm (
    .clk        (clk),
    .rst        (rst),
    .slave_en   (slave_en),
    .own_addr   (own_addr),
    .sda_lvl    (sda_lvl),
    .scl_rise   (scl_rise),
    .scl_fall   (scl_fall),
    .start_det  (start_det),
    .stop_det   (stop_det),
    .sda_pull   (sda_pull),
    .start_irq  (start_irq),
    .wake       (wake),
    .rx_valid   (rx_valid),
    .rx_byte    (rx_byte),
    .rx_is_addr (rx_is_addr)
  );
endmodule

// File: tb/i2c_addr_wake_test.sv
`timescale 1ns/1ps
module i2c_addr_wake_test;
  localparam int H = 8;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] mode = 2'b01;
  logic [6:0] own_addr = 7'h2D;
  logic       scl_m = 1'b1;
  logic       sda_m = 1'b1;
  logic       sda_pull, start_irq, wake, rx_valid, rx_is_addr;
  logic [7:0] rx_byte;
  logic       sda_line;

  int total = 0;
  int bad   = 0;
  int n_start = 0, n_wake = 0, n_rx = 0;
  logic [7:0] last_byte = 8'h00;
  logic       last_addr = 1'b0;

  always #4 clk = ~clk;
  assign sda_line = sda_m & ~sda_pull;

  i2c_addr_wake uut (
    .clk(clk), .rst(rst), .mode(mode), .own_addr(own_addr),
    .scl_in(scl_m), .sda_in(sda_line), .sda_pull(sda_pull),
    .start_irq(start_irq), .wake(wake), .rx_valid(rx_valid),
    .rx_byte(rx_byte), .rx_is_addr(rx_is_addr)
  );

  always @(posedge clk) begin
    if (start_irq) n_start <= n_start + 1;
    if (wake) n_wake <= n_wake + 1;
    if (rx_valid) begin
      n_rx      <= n_rx + 1;
      last_byte <= rx_byte;
      last_addr <= rx_is_addr;
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic wait_h();
    repeat (H) @(negedge clk);
  endtask

  task automatic i2c_start();
    sda_m = 1'b1; wait_h();
    scl_m = 1'b1; wait_h();
    sda_m = 1'b0; wait_h();
    scl_m = 1'b0; wait_h();
  endtask

  task automatic i2c_stop();
    sda_m = 1'b0; wait_h();
    scl_m = 1'b1; wait_h();
    sda_m = 1'b1; wait_h();
  endtask

  task automatic send_bit(input logic b, output logic pull_seen);
    sda_m = b; wait_h();
    scl_m = 1'b1;
    repeat (H/2) @(negedge clk);
    pull_seen = sda_pull;
    repeat (H - H/2) @(negedge clk);
    scl_m = 1'b0; wait_h();
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    logic dummy;
    for (int i = 7; i >= 0; i--) send_bit(b[i], dummy);
    send_bit(1'b1, ack);
  endtask

  int s0, w0, r0;
  logic ack;

  initial begin
    repeat (190000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    chk("R1", "reset outputs", {sda_pull, start_irq, wake, rx_valid, rx_is_addr, rx_byte}, 0);

    // Full address sweep in target-only mode (R2, R4, R5, R6)
    for (int a = 0; a < 128; a++) begin
      s0 = n_start; w0 = n_wake; r0 = n_rx;
      i2c_start();
      send_byte({a[6:0], a[0]}, ack);
      i2c_stop();
      chk("R2", "start pulses", n_start - s0, 1);
      chk("R4", "wake pulses", n_wake - w0, (a == 45) ? 1 : 0);
      chk("R5", "ack", ack, (a == 45) ? 1 : 0);
      if (a == 45) begin
        chk("R6", "addr byte", last_byte, {a[6:0], a[0]});
        chk("R6", "addr flag", last_addr, 1);
      end else begin
        chk("R8", "no rx on mismatch", n_rx - r0, 0);
      end
    end
    chk("R5", "released after ack", sda_pull, 0);

    // Mode sweep (R2, R3)
    for (int m = 0; m < 4; m++) begin
      mode = m[1:0];
      s0 = n_start; w0 = n_wake;
      i2c_start();
      send_byte({7'h2D, 1'b0}, ack);
      i2c_stop();
      chk("R3", "mode start irq", n_start - s0, m[0] ? 1 : 0);
      chk("R3", "mode wake", n_wake - w0, m[0] ? 1 : 0);
      chk("R3", "mode ack", ack, m[0] ? 1 : 0);
    end
    mode = 2'b01;

    // Matched write with data bytes (R7)
    i2c_start();
    send_byte({7'h2D, 1'b0}, ack);
    chk("R5", "write addr ack", ack, 1);
    for (int k = 0; k < 4; k++) begin
      logic [7:0] d;
      d = 8'(k * 8'h5B + 8'hA5);
      r0 = n_rx;
      send_byte(d, ack);
      chk("R7", "data ack", ack, 1);
      chk("R7", "data strobe", n_rx - r0, 1);
      chk("R7", "data byte", last_byte, d);
      chk("R7", "data flag", last_addr, 0);
    end
    i2c_stop();

    // Matched read: following bytes ignored (R8)
    i2c_start();
    send_byte({7'h2D, 1'b1}, ack);
    chk("R5", "read addr ack", ack, 1);
    r0 = n_rx;
    send_byte(8'h00, ack);
    chk("R8", "read byte no ack", ack, 0);
    chk("R8", "read byte no rx", n_rx - r0, 0);
    i2c_stop();

    // Mismatch followed by clocked data (R8)
    i2c_start();
    send_byte({7'h2C, 1'b0}, ack);
    r0 = n_rx;
    send_byte({7'h2D, 1'b0}, ack);
    chk("R8", "post-mismatch no ack", ack, 0);
    chk("R8", "post-mismatch no rx", n_rx - r0, 0);
    i2c_stop();

    // STOP mid-address (R9)
    w0 = n_wake;
    i2c_start();
    for (int i = 7; i >= 4; i--) begin
      logic p;
      send_bit(8'h5A >> i, p);
    end
    i2c_stop();
    chk("R9", "aborted addr no wake", n_wake - w0, 0);
    chk("R9", "aborted addr no pull", sda_pull, 0);
    w0 = n_wake;
    i2c_start();
    send_byte({7'h2D, 1'b0}, ack);
    i2c_stop();
    chk("R9", "transfer after abort ack", ack, 1);
    chk("R9", "transfer after abort wake", n_wake - w0, 1);

    // STOP mid-data-byte then a fresh write (R9)
    i2c_start();
    send_byte({7'h2D, 1'b0}, ack);
    for (int i = 0; i < 3; i++) begin
      logic p;
      send_bit(1'b0, p);
    end
    i2c_stop();
    r0 = n_rx;
    i2c_start();
    send_byte({7'h2D, 1'b0}, ack);
    send_byte(8'h3C, ack);
    i2c_stop();
    chk("R9", "fresh write strobes", n_rx - r0, 2);
    chk("R9", "fresh write byte", last_byte, 8'h3C);

    // Repeated START after mismatch and after matched read (R10)
    w0 = n_wake; s0 = n_start;
    i2c_start();
    send_byte({7'h11, 1'b0}, ack);
    chk("R10", "first addr mismatch", ack, 0);
    i2c_start();
    send_byte({7'h2D, 1'b1}, ack);
    chk("R10", "repeated start ack", ack, 1);
    send_byte(8'hFF, ack);
    i2c_start();
    send_byte({7'h2D, 1'b0}, ack);
    chk("R10", "second repeated start ack", ack, 1);
    i2c_stop();
    chk("R10", "repeated start wakes", n_wake - w0, 2);
    chk("R10", "repeated start irqs", n_start - s0, 3);

    // Extreme station addresses (R4)
    for (int o = 0; o < 2; o++) begin
      own_addr = o ? 7'h7F : 7'h00;
      for (int d = 0; d < 2; d++) begin
        logic [6:0] a;
        a = own_addr ^ {6'b0, d[0]};
        w0 = n_wake;
        i2c_start();
        send_byte({a, 1'b0}, ack);
        i2c_stop();
        chk("R4", "edge addr ack", ack, d == 0 ? 1 : 0);
        chk("R4", "edge addr wake", n_wake - w0, d == 0 ? 1 : 0);
      end
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule